// File: doc/BRIEF.md
# Serial Audio Output Frame Generator

This block builds the outgoing serial audio stream of a sample-rate conversion path. From one master clock it derives a bit clock at 64 times the output sample rate, a left/right clock at the sample rate and a word clock at twice the sample rate. It shifts two 16-bit samples, one per channel, onto a single data line. Each half frame has 32 bit periods: the sample goes out most significant bit first, starting in the first bit period, and zeros fill the rest.

The master clock runs at either 384 or 512 times the output sample rate, chosen by a ratio select, so one bit period lasts 6 or 8 master cycles. The upstream filter sees a one-cycle request pulse one bit period before every point where this block takes new samples. That gives it a full bit period to present the next values. At the normal output rate both channels are taken at the start of each frame. At the doubled output rate each half frame is its own slot, so the right sample is taken at the half-frame boundary. In pass-through mode the data stream is left alone, the word clock is held low and the block takes samples once per frame.

Top module: `audio_frame_gen`

## Requirements
- R1: The bit clock period is 6 master cycles when `ratioSel` is 0 and 8 when it is 1, with equal high and low times.
- R2: `lrckO` is high for the 32 bit periods carrying the left channel and low for the 32 carrying the right. It changes only in the master cycle in which `bclkO` falls.
- R3: Outside pass-through, `wclkO` is high for bit slots 0 to 15 of each half frame and low for slots 16 to 31. It changes only when `bclkO` falls.
- R4: While `passThru` is 1, `wclkO` stays low.
- R5: In each half frame, slot k (k = 0..15) carries bit 15-k of that channel's sample and slots 16 to 31 carry 0. `sdataO` changes only when `bclkO` falls.
- R6: Both samples are taken from `leftIn`/`rightIn` at the start of every frame. Input changes at any other time have no effect on the frame in progress when `rateSel` is 0.
- R7: When `rateSel` is 1 and `passThru` is 0, the left sample is taken at the start of the frame and the right sample at the start of the right half.
- R8: `sampleReqO` is a one-master-cycle pulse. It rises together with the bit clock fall that opens bit 63, and also the one that opens bit 31 when `rateSel` is 1 and `passThru` is 0.
- R9: While `passThru` is 1, `rateSel` has no effect: one request and one sample pair per frame.
- R10: While `rstN` is low, `bclkO` is 1 and the other outputs are 0. The first bit clock fall after reset starts a left half, carrying the samples present when reset was released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 1 | Master ratio: 0 = 384 fs, 1 = 512 fs |
| passThru | input | 1 | Pass-through mode, word clock held low |
| rateSel | input | 1 | Output data rate: 0 = fs, 1 = 2 fs |
| leftIn | input | 16 | Left channel sample |
| rightIn | input | 16 | Right channel sample |
| bclkO | output | 1 | Bit clock, 64 fs |
| lrckO | output | 1 | Left/right clock, fs, high for left |
| wclkO | output | 1 | Word clock, 2 fs |
| sdataO | output | 1 | Serial data |
| sampleReqO | output | 1 | Request for the next sample(s) |

## Verification
The assertions assume that `ratioSel`, `rateSel` and `passThru` only change while reset is held, since a change mid-frame would shorten a bit period. They also assume that the sample inputs are only updated after a request pulse. The bench keeps to both assumptions. It walks every combination of the three mode pins, each under a fresh reset, and draws new samples only on a request. The one exception is a deliberate change in the middle of a normal-rate frame, placed where the design must ignore it.

// File: rtl/afg_pkg.sv
package afg_pkg;
  parameter int SLOT_LEN   = 32;
  parameter int SLOT_IDX_W = $clog2(SLOT_LEN);

  typedef struct packed {
    logic                  bclkLvl;
    logic                  lrckLvl;
    logic                  wclkLvl;
    logic [SLOT_IDX_W-1:0] slot;
    logic                  latchL;
    logic                  latchR;
    logic                  reqPulse;
  } afg_strobe_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import afg_pkg::*;
#(
  parameter int DIV_LO  = 6,
  parameter int DIV_HI  = 8,
  parameter int SLOT_N  = SLOT_LEN
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ratioSel,
  input  logic        passThru,
  input  logic        rateSel,
  output afg_strobe_t strb
);
  localparam int PH_W      = $clog2(DIV_HI);
  localparam int FRAME_LEN = 2 * SLOT_N;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int WORD_LEN  = SLOT_N / 2;

  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  divM1;
  logic [PH_W-1:0]  halfDiv;
  logic [CNT_W-1:0] bitCnt;
  logic             wrap;
  logic             twoFs;
  logic             frameEnd;
  logic             halfEnd;
  logic             leftHalf;
  logic [SLOT_IDX_W-1:0] slotIdx;

  always_comb begin
    divM1   = ratioSel ? PH_W'(DIV_HI - 1) : PH_W'(DIV_LO - 1);
    halfDiv = ratioSel ? PH_W'(DIV_HI / 2) : PH_W'(DIV_LO / 2);
    wrap    = (ph >= divM1);
    twoFs   = rateSel && !passThru;
    frameEnd = (bitCnt == CNT_W'(FRAME_LEN - 1));
    halfEnd  = (bitCnt == CNT_W'(SLOT_N - 1));
    leftHalf = (bitCnt < CNT_W'(SLOT_N));
    slotIdx  = leftHalf ? SLOT_IDX_W'(bitCnt) : SLOT_IDX_W'(bitCnt - CNT_W'(SLOT_N));
  end

  // phase within a bit period and bit position within the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph     <= PH_W'(DIV_HI - 1);
      bitCnt <= CNT_W'(FRAME_LEN - 1);
    end else if (wrap) begin
      ph     <= '0;
      bitCnt <= frameEnd ? '0 : bitCnt + 1'b1;
    end else begin
      ph     <= ph + 1'b1;
    end
  end

  always_comb begin
    strb.bclkLvl  = (ph >= halfDiv);
    strb.lrckLvl  = leftHalf;
    strb.slot     = slotIdx;
    strb.wclkLvl  = !passThru && (slotIdx < SLOT_IDX_W'(WORD_LEN));
    strb.latchL   = wrap && frameEnd;
    strb.latchR   = wrap && (frameEnd ? !twoFs : (halfEnd && twoFs));
    strb.reqPulse = (ph == '0) && (frameEnd || (halfEnd && twoFs));
  end

  // a request is never issued in the same cycle as a latch
  assert_req_not_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqPulse |-> !(strb.latchL || strb.latchR));

  // at the normal rate both channels are taken together
  assert_pair_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchL && !rateSel) |-> strb.latchR);

  // in pass-through, no mid-frame right latch regardless of rate select
  assert_pass_no_mid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (passThru && strb.latchR) |-> strb.latchL);
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import afg_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                passThru,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  afg_strobe_t         strb,
  output logic                bclkO,
  output logic                lrckO,
  output logic                wclkO,
  output logic                sdataO,
  output logic                sampleReqO
);
  localparam int SMP_IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0]  holdL;
  logic [SAMPLE_W-1:0]  holdR;
  logic [SAMPLE_W-1:0]  chanWord;
  logic [SMP_IDX_W-1:0] bitSel;
  logic                 inWord;
  logic                 nextBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
    end else begin
      if (strb.latchL) holdL <= leftIn;
      if (strb.latchR) holdR <= rightIn;
    end
  end

  always_comb begin
    chanWord = strb.lrckLvl ? holdL : holdR;
    inWord   = (strb.slot < SLOT_IDX_W'(SAMPLE_W));
    bitSel   = SMP_IDX_W'(SAMPLE_W - 1) - SMP_IDX_W'(strb.slot);
    nextBit  = inWord ? chanWord[bitSel] : 1'b0;
  end

  // all outputs registered together so they share one edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkO      <= 1'b1;
      lrckO      <= 1'b0;
      wclkO      <= 1'b0;
      sdataO     <= 1'b0;
      sampleReqO <= 1'b0;
    end else begin
      bclkO      <= strb.bclkLvl;
      lrckO      <= strb.lrckLvl;
      wclkO      <= strb.wclkLvl;
      sdataO     <= nextBit;
      sampleReqO <= strb.reqPulse;
    end
  end

  assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrckO) |-> $fell(bclkO));

  assert_wclk_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wclkO) |-> $fell(bclkO));

  assert_wclk_pass_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (passThru && $past(passThru)) |-> !wclkO);

  assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdataO) |-> $fell(bclkO));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchL |=> $stable(holdL));

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleReqO |=> !sampleReqO);

  assert_req_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleReqO) |-> $fell(bclkO));
endmodule

// File: rtl/audio_frame_gen.sv
module audio_frame_gen
  import afg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_LO   = 6,
  parameter int DIV_HI   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ratioSel,
  input  logic                passThru,
  input  logic                rateSel,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                bclkO,
  output logic                lrckO,
  output logic                wclkO,
  output logic                sdataO,
  output logic                sampleReqO
);
  afg_strobe_t strb;

  frame_ctrl #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .SLOT_N (SLOT_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .passThru (passThru),
    .rateSel  (rateSel),
    .strb     (strb)
  );

  frame_datapath #(
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .passThru   (passThru),
    .leftIn     (leftIn),
    .rightIn    (rightIn),
    .strb       (strb),
    .bclkO      (bclkO),
    .lrckO      (lrckO),
    .wclkO      (wclkO),
    .sdataO     (sdataO),
    .sampleReqO (sampleReqO)
  );
endmodule

// File: tb/sim_audio_frame_gen.sv
`timescale 1ns/1ps
module sim_audio_frame_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ratioSel = 1'b0;
  logic        passThru = 1'b0;
  logic        rateSel = 1'b0;
  logic [15:0] leftIn = '0;
  logic [15:0] rightIn = '0;
  logic        bclkO, lrckO, wclkO, sdataO, sampleReqO;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  audio_frame_gen u0 (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .passThru(passThru),
    .rateSel(rateSel), .leftIn(leftIn), .rightIn(rightIn),
    .bclkO(bclkO), .lrckO(lrckO), .wclkO(wclkO), .sdataO(sdataO),
    .sampleReqO(sampleReqO)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  function automatic int divOf(input bit r);
    return r ? 8 : 6;
  endfunction

  function automatic bit expBit(input logic [15:0] s, input int slot);
    return (slot < 16) ? s[15 - slot] : 1'b0;
  endfunction

  int pickN = 0;
  function automatic logic [15:0] pickSample(input int n);
    case (n % 7)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0001;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  // monitor state
  bit monOn = 0;
  bit prevB, lastLr, haveRise, firstRise;
  int bitIdx, sinceRise, hiCnt, frames;
  int timErr, lrErr, wcErr, reqCnt, reqErr;
  logic [63:0] capt;
  logic [15:0] snapL, snapR;

  always @(negedge clk) begin
    bit twoFsExp;
    int dv;
    twoFsExp = rateSel && !passThru;
    dv = divOf(ratioSel);
    if (!monOn) begin
      prevB = 1; lastLr = 0; haveRise = 0; firstRise = 1;
      bitIdx = -1; sinceRise = 0; hiCnt = 0; frames = 0;
      timErr = 0; lrErr = 0; wcErr = 0; reqCnt = 0; reqErr = 0;
    end else begin
      sinceRise++;
      if (bclkO) hiCnt++;
      if (sampleReqO) begin
        if (!((bitIdx == 62) || (twoFsExp && bitIdx == 30))) reqErr++;
        reqCnt++;
        pickN++; leftIn = pickSample(pickN);
        pickN++; rightIn = pickSample(pickN);
      end
      if (!prevB && bclkO) begin
        if (haveRise && sinceRise != dv) timErr++;
        haveRise = 1; sinceRise = 0;
        if (firstRise) begin
          check(lrckO == 1'b1, "R10", "first half after reset is left", lrckO, 1);
          firstRise = 0;
        end
        if (lrckO && !lastLr) bitIdx = 0;
        else bitIdx++;
        lastLr = lrckO;
        if (bitIdx > 63) begin lrErr++; bitIdx = 63; end
        capt[bitIdx] = sdataO;
        if (lrckO != (bitIdx < 32)) lrErr++;
        if (wclkO != (!passThru && ((bitIdx % 32) < 16))) wcErr++;
        if (bitIdx == 0) begin snapL = leftIn; snapR = rightIn; end
        if (bitIdx == 32 && twoFsExp) snapR = rightIn;
        if (bitIdx == 10 && !twoFsExp) begin
          // unrequested change mid-frame: must not reach this frame (R6)
          pickN++; leftIn = pickSample(pickN);
          pickN++; rightIn = pickSample(pickN);
        end
        if (bitIdx == 63) begin
          int badL, badR, badPad;
          badL = 0; badR = 0; badPad = 0;
          for (int k = 0; k < 16; k++) begin
            if (capt[k] != expBit(snapL, k)) badL++;
            if (capt[32 + k] != expBit(snapR, k)) badR++;
          end
          for (int k = 16; k < 32; k++) begin
            if (capt[k] != 1'b0) badPad++;
            if (capt[32 + k] != 1'b0) badPad++;
          end
          check(badL == 0, "R6", "left word bit errors", badL, 0);
          if (twoFsExp) check(badR == 0, "R7", "right word bit errors (2fs)", badR, 0);
          else if (passThru && rateSel)
            check(badR == 0, "R9", "right word bit errors (pass)", badR, 0);
          else check(badR == 0, "R6", "right word bit errors", badR, 0);
          check(badPad == 0, "R5", "pad slot errors", badPad, 0);
          check(timErr == 0, "R1", "bit clock timing errors", timErr, 0);
          check(lrErr == 0, "R2", "lr clock errors", lrErr, 0);
          if (passThru) check(wcErr == 0, "R4", "word clock not low", wcErr, 0);
          else check(wcErr == 0, "R3", "word clock errors", wcErr, 0);
          if (passThru && rateSel)
            check(reqCnt == 1 && reqErr == 0, "R9", "requests per frame", reqCnt, 1);
          else
            check(reqCnt == (twoFsExp ? 2 : 1) && reqErr == 0, "R8",
                  "requests per frame", reqCnt, twoFsExp ? 2 : 1);
          frames++;
          timErr = 0; lrErr = 0; wcErr = 0; reqCnt = 0; reqErr = 0;
        end
      end
      if (prevB && !bclkO) begin
        if (haveRise && hiCnt != dv / 2) timErr++;
        hiCnt = 0;
      end
      prevB = bclkO;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "R1", "watchdog expired", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int cfg = 0; cfg < 8; cfg++) begin
      @(negedge clk);
      monOn = 0;
      rstN = 0;
      ratioSel = cfg[0];
      rateSel = cfg[1];
      passThru = cfg[2];
      pickN++; leftIn = pickSample(pickN + 4);
      pickN++; rightIn = pickSample(pickN + 4);
      repeat (4) @(negedge clk);
      check(bclkO == 1 && !lrckO && !wclkO && !sdataO && !sampleReqO, "R10",
            "outputs under reset", {bclkO, lrckO, wclkO, sdataO, sampleReqO}, 5'b10000);
      monOn = 1;
      rstN = 1;
      wait (frames >= 4);
    end
    finishRun();
  end
endmodule